// File: doc/BRIEF.md
# Pausible Local Clock Generator

This block produces the local clock of a synchronous island from a fast reference clock. A reload counter sets the length of each half-cycle and stands in for a delay line. The clock runs freely until a neighbour asks to stop it through a four-phase pause handshake. A small mutual-exclusion stage then decides against the clock's own wish to start a new cycle. The outcome fixes whether the pause lands at the end of the current cycle or of the next one. A cycle that has begun always finishes, so the island never sees a truncated high phase.

An active-low stretch input serves the output side of the island. While an outgoing transfer is still unacknowledged, the stretch input holds the clock low and defers its next rising edge. It has no effect on the falling edge. Arbitration is deterministic: when the pause request and the clock's run request arrive in the same reference cycle, a parameter decides which side wins.

Top module: `pausible_clock_gen`

## Requirements
- R1: Synchronous reset (rst high) leaves lclk low, grant and run low, and pause_ack high.
- R2: With pause_req low and stretch_n high, lclk toggles every HALF_CYC reference cycles, giving a period of 2*HALF_CYC (8 with the default HALF_CYC=4).
- R3: Every high phase of lclk lasts exactly HALF_CYC reference cycles, even when a pause request arrives during it.
- R4: grant and run are never high together, and grant is high only if pause_req was high in the previous reference cycle.
- R5: A pause_req that rises while lclk is high raises grant one reference cycle later. lclk then falls at the normal end of its high phase and stays low.
- R6: A pause_req that rises while lclk is low and run is already held does not cut the low phase. lclk rises at its normal time, completes one high phase, and only then halts low.
- R7: A pause_req that rises in the same reference cycle in which lclk first shows its low phase is a tie. With TIE_PAUSE_WINS=1 (default), grant wins, run stays low and lclk does not rise again while the request is held.
- R8: pause_ack falls one reference cycle after grant is high with lclk low. It returns high two reference cycles after pause_req falls.
- R9: When pause_req falls while the clock is paused low, lclk rises two reference cycles later without waiting for a further half-period.
- R10: While stretch_n is low during a low phase, lclk stays low. Once stretch_n returns high after the half-period has elapsed, lclk rises one reference cycle later.
- R11: stretch_n low during a high phase has no effect: lclk still falls after HALF_CYC reference cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Fast reference clock |
| rst | input | 1 | Synchronous active-high reset |
| pause_req | input | 1 | Four-phase request to pause the local clock |
| stretch_n | input | 1 | Active-low hold of the next rising edge |
| lclk | output | 1 | Generated local clock (registered) |
| pause_ack | output | 1 | Four-phase acknowledge, low while paused |
| grant | output | 1 | Mutual-exclusion outcome: pause request holds the stage |
| run | output | 1 | Mutual-exclusion outcome: clock holds the stage for a new cycle |

## Verification
The bench places pause requests on each side of the phase boundary. A request during a high phase must not shorten that phase, and a design that halted at once would show a short high time. A request during an already granted low phase must let one more full cycle through. The tie case, with the request arriving just as the low phase begins, must stop the clock before any further rising edge; giving the tie to run would show an extra cycle. Stretch is applied in both phases, where a design that also gated falling edges would lengthen the high phase. The release latency is measured to catch a design that waits a full half-period before restarting.

// File: rtl/pclk_pkg.sv
package pclk_pkg;

  // Holder of the mutual-exclusion stage
  typedef enum logic [1:0] {
    MX_FREE  = 2'd0,
    MX_PAUSE = 2'd1,
    MX_RUN   = 2'd2
  } mx_owner_t;

  function automatic int unsigned cnt_width(input int unsigned half);
    return (half < 2) ? 1 : $clog2(half);
  endfunction

endpackage

// File: rtl/pclk_phase_timer.sv
module pclk_phase_timer #(
  parameter int unsigned HALF_CYC = 4
) (
  input  logic clk_ref,
  input  logic rst,
  input  logic reload,
  output logic expired
);
  import pclk_pkg::*;

  localparam int unsigned CW = cnt_width(HALF_CYC);
  localparam logic [CW-1:0] START = CW'(HALF_CYC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_ref) begin
    if (rst) begin
      cnt_q <= START;
    end else if (reload) begin
      cnt_q <= START;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/pclk_mutex.sv
module pclk_mutex #(
  parameter bit TIE_PAUSE_WINS = 1'b1
) (
  input  logic clk_ref,
  input  logic rst,
  input  logic want_pause,
  input  logic want_run,
  output logic grant,
  output logic run
);
  import pclk_pkg::*;

  mx_owner_t owner_q, owner_d;

  always_comb begin
    owner_d = MX_FREE;
    if (owner_q == MX_PAUSE && want_pause) begin
      owner_d = MX_PAUSE;
    end else if (owner_q == MX_RUN && want_run) begin
      owner_d = MX_RUN;
    end else if (want_pause && want_run) begin
      owner_d = TIE_PAUSE_WINS ? MX_PAUSE : MX_RUN;
    end else if (want_pause) begin
      owner_d = MX_PAUSE;
    end else if (want_run) begin
      owner_d = MX_RUN;
    end
  end

  always_ff @(posedge clk_ref) begin
    if (rst) owner_q <= MX_FREE;
    else     owner_q <= owner_d;
  end

  assign grant = (owner_q == MX_PAUSE);
  assign run   = (owner_q == MX_RUN);

endmodule

// File: rtl/pclk_edge_ctrl.sv
module pclk_edge_ctrl (
  input  logic clk_ref,
  input  logic rst,
  input  logic expired,
  input  logic run,
  input  logic grant,
  input  logic stretch_n,
  output logic lclk,
  output logic reload,
  output logic pause_ack
);

  logic lclk_q, ack_q;
  logic rise_ok, fall_ok;

  // A started cycle always completes: falling needs only the timer.
  assign fall_ok = lclk_q && expired;
  // Rising needs the timer, the run token and no stretch.
  assign rise_ok = !lclk_q && expired && run && stretch_n;
  assign reload  = rise_ok || fall_ok;

  always_ff @(posedge clk_ref) begin
    if (rst) begin
      lclk_q <= 1'b0;
      ack_q  <= 1'b1;
    end else begin
      if (reload) lclk_q <= !lclk_q;
      ack_q <= !(grant && !lclk_q);
    end
  end

  assign lclk      = lclk_q;
  assign pause_ack = ack_q;

endmodule

// File: rtl/pausible_clock_gen.sv
module pausible_clock_gen #(
  parameter int unsigned HALF_CYC       = 4,
  parameter bit          TIE_PAUSE_WINS = 1'b1
) (
  input  logic clk_ref,
  input  logic rst,
  input  logic pause_req,
  input  logic stretch_n,
  output logic lclk,
  output logic pause_ack,
  output logic grant,
  output logic run
);

  logic expired, reload;

  pclk_phase_timer #(.HALF_CYC(HALF_CYC)) u_timer (
    .clk_ref (clk_ref),
    .rst     (rst),
    .reload  (reload),
    .expired (expired)
  );

  pclk_mutex #(.TIE_PAUSE_WINS(TIE_PAUSE_WINS)) u_mutex (
    .clk_ref    (clk_ref),
    .rst        (rst),
    .want_pause (pause_req),
    .want_run   (!lclk),
    .grant      (grant),
    .run        (run)
  );

  pclk_edge_ctrl u_edge (
    .clk_ref   (clk_ref),
    .rst       (rst),
    .expired   (expired),
    .run       (run),
    .grant     (grant),
    .stretch_n (stretch_n),
    .lclk      (lclk),
    .reload    (reload),
    .pause_ack (pause_ack)
  );

endmodule

// File: rtl/pausible_clock_gen_chk.sv
module pausible_clock_gen_chk #(
  parameter int unsigned HALF_CYC = 4
) (
  input logic clk_ref,
  input logic rst,
  input logic pause_req,
  input logic stretch_n,
  input logic lclk,
  input logic pause_ack,
  input logic grant,
  input logic run
);

  int unsigned hi_len;

  always_ff @(posedge clk_ref) begin
    if (rst)       hi_len <= 0;
    else if (lclk) hi_len <= hi_len + 1;
    else           hi_len <= 0;
  end

  // R4
  mutex_excl_chk: assert property (@(posedge clk_ref) disable iff (rst)
    !(grant && run));

  // R4
  grant_needs_req_chk: assert property (@(posedge clk_ref) disable iff (rst)
    grant |-> $past(pause_req));

  // R3
  high_phase_len_chk: assert property (@(posedge clk_ref) disable iff (rst)
    $fell(lclk) |-> (hi_len == HALF_CYC));

  // R5
  no_rise_when_granted_chk: assert property (@(posedge clk_ref) disable iff (rst)
    $rose(lclk) |-> ($past(run) && !$past(grant)));

  // R10
  stretch_holds_low_chk: assert property (@(posedge clk_ref) disable iff (rst)
    (!stretch_n && !lclk) |=> !lclk);

  // R8
  ack_falls_chk: assert property (@(posedge clk_ref) disable iff (rst)
    (grant && !lclk) |=> !pause_ack);

endmodule

bind pausible_clock_gen pausible_clock_gen_chk #(.HALF_CYC(HALF_CYC)) u_chk (
  .clk_ref   (clk_ref),
  .rst       (rst),
  .pause_req (pause_req),
  .stretch_n (stretch_n),
  .lclk      (lclk),
  .pause_ack (pause_ack),
  .grant     (grant),
  .run       (run)
);

// File: tb/sim_pausible_clock_gen.sv
module sim_pausible_clock_gen;

  localparam time CLK_PERIOD = 10ns;
  localparam int  HALF = 4;

  logic clk_ref = 1'b0;
  logic rst = 1'b1;
  logic pause_req = 1'b0;
  logic stretch_n = 1'b1;
  logic lclk, pause_ack, grant, run;

  int n_chk = 0;
  int n_fail = 0;
  int excl_viol = 0;

  always #(CLK_PERIOD/2) clk_ref = ~clk_ref;

  pausible_clock_gen #(.HALF_CYC(HALF), .TIE_PAUSE_WINS(1'b1)) u0 (
    .clk_ref(clk_ref), .rst(rst), .pause_req(pause_req), .stretch_n(stretch_n),
    .lclk(lclk), .pause_ack(pause_ack), .grant(grant), .run(run)
  );

  always @(negedge clk_ref) if (!rst && grant && run) excl_viol++;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Called at a negedge; returns negedges waited until lclk == v
  task automatic wait_lvl(input logic v, output int n);
    n = 0;
    while (lclk !== v && n < 200) begin
      @(negedge clk_ref);
      n++;
    end
  endtask

  task automatic idle(input int k);
    for (int i = 0; i < k; i++) @(negedge clk_ref);
  endtask

  task automatic t_reset();
    @(negedge clk_ref);
    chk("R1 lclk", lclk, 0);
    chk("R1 grant", grant, 0);
    chk("R1 run", run, 0);
    chk("R1 ack", pause_ack, 1);
    rst = 1'b0;
  endtask

  task automatic t_freerun();
    int n;
    wait_lvl(1'b1, n);
    wait_lvl(1'b0, n);
    chk("R2 high len", n, HALF);
    wait_lvl(1'b1, n);
    chk("R2 low len", n, HALF);
    wait_lvl(1'b0, n);
    wait_lvl(1'b1, n);
    chk("R2 low len again", n, HALF);
  endtask

  task automatic t_pause_high();
    int n;
    wait_lvl(1'b0, n);
    wait_lvl(1'b1, n);
    pause_req = 1'b1;
    @(negedge clk_ref);
    chk("R5 grant next cycle", grant, 1);
    wait_lvl(1'b0, n);
    chk("R3 high completes", n, HALF - 1);
    idle(12);
    chk("R5 halted low", lclk, 0);
    chk("R8 ack low", pause_ack, 0);
    chk("R4 run low while paused", run, 0);
    pause_req = 1'b0;
    wait_lvl(1'b1, n);
    chk("R9 restart latency", n, 2);
    chk("R8 ack back high", pause_ack, 1);
    chk("R4 grant released", grant, 0);
  endtask

  task automatic t_pause_low();
    int n;
    wait_lvl(1'b0, n);
    wait_lvl(1'b1, n);
    wait_lvl(1'b0, n);
    @(negedge clk_ref);
    pause_req = 1'b1;
    wait_lvl(1'b1, n);
    chk("R6 rise on time", n, HALF - 1);
    wait_lvl(1'b0, n);
    chk("R6 high completes", n, HALF);
    idle(12);
    chk("R6 halted low", lclk, 0);
    chk("R6 grant held", grant, 1);
    pause_req = 1'b0;
    wait_lvl(1'b1, n);
    chk("R9 restart after low pause", n, 2);
  endtask

  task automatic t_tie();
    int n;
    wait_lvl(1'b0, n);
    wait_lvl(1'b1, n);
    wait_lvl(1'b0, n);
    pause_req = 1'b1;
    @(negedge clk_ref);
    chk("R7 tie grant", grant, 1);
    chk("R7 tie run", run, 0);
    idle(15);
    chk("R7 no further rise", lclk, 0);
    pause_req = 1'b0;
    wait_lvl(1'b1, n);
    chk("R9 restart after tie", n, 2);
  endtask

  task automatic t_stretch();
    int n;
    wait_lvl(1'b0, n);
    stretch_n = 1'b0;
    idle(HALF + 8);
    chk("R10 held low", lclk, 0);
    stretch_n = 1'b1;
    @(negedge clk_ref);
    chk("R10 rise after release", lclk, 1);
    wait_lvl(1'b0, n);
    wait_lvl(1'b1, n);
    stretch_n = 1'b0;
    wait_lvl(1'b0, n);
    chk("R11 high unaffected", n, HALF);
    stretch_n = 1'b1;
  endtask

  initial begin
    idle(3);
    t_reset();
    t_freerun();
    t_pause_high();
    t_pause_low();
    t_tie();
    t_stretch();
    idle(4);
    chk("R4 exclusivity monitor", excl_viol, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule